// File: doc/BRIEF.md
# Bit-Oriented Receiver Frame-End Status Path

This block sits behind the flag hunter, zero-bit remover and CRC checker of a bit-oriented serial receiver running with 8-bit characters. It packs the incoming serial bits into characters and queues them for a processor. Each queued character travels with a status word that holds a frame-end mark, a CRC error mark and a residue code. When the closing flag of a frame is reported, whatever is in the shift register goes into the queue as the last character of the frame. If that character is short, its number of leftover bits is encoded as a non-binary three-bit residue code.

When the processor reads the frame-end character, the queue locks. Further reads are refused and the frame's status stays visible on the status outputs. Characters that keep arriving are queued with their frame-end mark forced on. A single error-reset command clears the lock and the sticky overrun flag. An interrupt output is driven according to a two-bit mode input.

Top module: `sdlc_rx_eof_status`

## Requirements
- R1: Serial bits are shifted in least significant bit first, so the first bit of a character lands in bit 0. A completed 8-bit character is held until the next bit or a frame-end indication arrives, and only then is it queued.
- R2: A frame-end indication with k held bits (k from 1 to 7) queues the shift contents with the received bits in the top k positions (first received bit at position 8-k) and zeros below. With no bits held, nothing is queued.
- R3: The residue code of a final character, as a vector [2:0], is 6,7,0,1,2,3,4,5 for 0 to 7 leftover bits, where a completed 8-bit final character counts as 0 leftover bits. Non-final entries carry code 6, CRC error 0 and, while unlocked, frame-end 0.
- R4: The crc_bad input sampled with the frame-end indication is stored as the CRC error mark of the final character.
- R5: The character queue and the status queue are each 3 deep and move together. rd_valid shows a non-empty queue, and one rd_pop removes one entry from both.
- R6: Popping an entry whose frame-end mark is set locks the queue. While locked, rd_pop is ignored, and rd_resid and rd_crc_err show the popped frame's status with rd_eof high.
- R7: Every character queued while locked has its frame-end mark set.
- R8: err_reset clears the lock and the overrun flag on the next edge.
- R9: A character that arrives while the queue is full and no pop is taken is dropped, and the overrun output is set and held.
- R10: With int_mode 00, irq is low. In every other mode, irq is high while locked or in overrun. Mode 11 adds nothing more. Mode 10 also raises irq while an unlocked entry waits. Mode 01 also raises irq while the waiting head entry is the first character of its frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bit_vld | input | 1 | A destuffed data bit is present |
| rx_bit | input | 1 | Destuffed data bit value |
| rx_flag_end | input | 1 | Closing flag seen this cycle |
| crc_bad | input | 1 | CRC check failed, sampled with rx_flag_end |
| int_mode | input | 2 | Interrupt mode select |
| rd_pop | input | 1 | Processor read of the head entry |
| err_reset | input | 1 | Error-reset command |
| rd_valid | output | 1 | Queue holds an entry |
| rd_data | output | 8 | Head character |
| rd_resid | output | 3 | Residue code (frame status while locked) |
| rd_crc_err | output | 1 | CRC error mark (frame status while locked) |
| rd_eof | output | 1 | Frame-end mark of head, or locked |
| overrun | output | 1 | Sticky overrun flag |
| irq | output | 1 | Interrupt request |

## Verification
Frames are sent as three whole characters, as one whole character followed by every short tail length from one to seven bits, and as a stream that keeps arriving after the lock. The whole-character frames separate the held-character rule from an early push and check residue code 6. The tail sweep pins down each residue code and the top-aligned bit placement, and alternates the CRC mark so that a stuck error bit is caught. The post-lock stream and a four-character burst into a three-entry queue separate the lock's forced frame-end mark from ordinary status and show which character is dropped. Each interrupt mode is tried against the same head states so that the modes differ in what they report.

// File: rtl/rxeof_pkg.sv
package rxeof_pkg;

  typedef enum logic [1:0] {
    IRQ_OFF     = 2'b00,
    IRQ_FIRST   = 2'b01,
    IRQ_ALL     = 2'b10,
    IRQ_SPECIAL = 2'b11
  } irq_mode_e;

  typedef struct packed {
    logic       first;
    logic       eof;
    logic       crc;
    logic [2:0] resid;
  } stat_t;

  // leftover bit count of the final character -> non-binary residue code
  function automatic logic [2:0] residue_code(input logic [2:0] left);
    logic [2:0] code;
    case (left)
      3'd0:    code = 3'b110;
      3'd1:    code = 3'b111;
      3'd2:    code = 3'b000;
      3'd3:    code = 3'b001;
      3'd4:    code = 3'b010;
      3'd5:    code = 3'b011;
      3'd6:    code = 3'b100;
      default: code = 3'b101;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/rxeof_assembler.sv
module rxeof_assembler #(
  parameter int CHAR_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bit_vld,
  input  logic                          bit_in,
  input  logic                          flag_end,
  output logic                          push_ev,
  output logic [CHAR_W-1:0]             push_data,
  output logic                          push_final,
  output logic [$clog2(CHAR_W)-1:0]     push_left,
  output logic [$clog2(CHAR_W+1)-1:0]   cnt_o
);
  localparam int CW = $clog2(CHAR_W + 1);
  localparam int LW = $clog2(CHAR_W);

  logic [CHAR_W-1:0] sh_q;
  logic [CW-1:0]     cnt_q;
  logic              full_char;

  assign full_char = (cnt_q == CW'(CHAR_W));
  assign cnt_o     = cnt_q;

  always_comb begin
    push_ev    = 1'b0;
    push_final = 1'b0;
    push_data  = sh_q;
    push_left  = full_char ? '0 : LW'(cnt_q);
    if (flag_end) begin
      push_ev    = (cnt_q != '0);
      push_final = 1'b1;
    end else if (bit_vld && full_char) begin
      push_ev = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (flag_end) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (bit_vld) begin
      if (full_char) begin
        sh_q  <= {bit_in, {(CHAR_W-1){1'b0}}};
        cnt_q <= CW'(1);
      end else begin
        sh_q  <= {bit_in, sh_q[CHAR_W-1:1]};
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

endmodule

// File: rtl/rxeof_fifo.sv
module rxeof_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [W-1:0]                 wr_data,
  input  logic                         rd_en,
  output logic [W-1:0]                 rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] lvl_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign rd_data = mem[rptr_q];
  assign level   = lvl_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      if (wr_en) wptr_q <= ptr_inc(wptr_q);
      if (rd_en) rptr_q <= ptr_inc(rptr_q);
      case ({wr_en, rd_en})
        2'b10:   lvl_q <= lvl_q + LW'(1);
        2'b01:   lvl_q <= lvl_q - LW'(1);
        default: lvl_q <= lvl_q;
      endcase
    end
  end

endmodule

// File: rtl/rxeof_irq.sv
module rxeof_irq
  import rxeof_pkg::*;
(
  input  irq_mode_e mode,
  input  logic      head_valid,
  input  logic      head_first,
  input  logic      locked,
  input  logic      overrun,
  output logic      irq
);
  logic special;
  assign special = locked | overrun;

  always_comb begin
    case (mode)
      IRQ_FIRST:   irq = special | (head_valid & head_first & ~locked);
      IRQ_ALL:     irq = special | (head_valid & ~locked);
      IRQ_SPECIAL: irq = special;
      default:     irq = 1'b0;
    endcase
  end

endmodule

// File: rtl/sdlc_rx_eof_status.sv
module sdlc_rx_eof_status
  import rxeof_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit_vld,
  input  logic              rx_bit,
  input  logic              rx_flag_end,
  input  logic              crc_bad,
  input  logic [1:0]        int_mode,
  input  logic              rd_pop,
  input  logic              err_reset,
  output logic              rd_valid,
  output logic [CHAR_W-1:0] rd_data,
  output logic [2:0]        rd_resid,
  output logic              rd_crc_err,
  output logic              rd_eof,
  output logic              overrun,
  output logic              irq
);
  localparam int CW = $clog2(CHAR_W + 1);
  localparam int LW = $clog2(CHAR_W);
  localparam int QW = $clog2(DEPTH + 1);
  localparam int SW = $bits(stat_t);

  // named internal events
  logic              push_ev, push_final, push_ok, push_drop, pop_ev;
  logic [CHAR_W-1:0] push_data;
  logic [LW-1:0]     push_left;
  logic [CW-1:0]     asm_cnt;
  logic [QW-1:0]     dlevel, slevel;
  logic              q_empty, q_full;
  logic              head_eof;
  stat_t             push_stat, head_stat, frame_stat_q;
  logic              locked_q, ovr_q, frame_start_q;

  rxeof_assembler #(.CHAR_W(CHAR_W)) u_asm (
    .clk, .rst_n,
    .bit_vld   (rx_bit_vld),
    .bit_in    (rx_bit),
    .flag_end  (rx_flag_end),
    .push_ev   (push_ev),
    .push_data (push_data),
    .push_final(push_final),
    .push_left (push_left),
    .cnt_o     (asm_cnt)
  );

  assign q_empty   = (dlevel == '0);
  assign q_full    = (dlevel == QW'(DEPTH));
  assign pop_ev    = rd_pop & ~q_empty & ~locked_q;
  assign push_ok   = push_ev & (~q_full | pop_ev);
  assign push_drop = push_ev & ~push_ok;

  always_comb begin
    push_stat.first = frame_start_q;
    push_stat.eof   = push_final | locked_q;
    push_stat.crc   = push_final & crc_bad;
    push_stat.resid = residue_code(push_final ? 3'(push_left) : 3'd0);
  end

  rxeof_fifo #(.W(CHAR_W), .DEPTH(DEPTH)) u_dq (
    .clk, .rst_n,
    .wr_en  (push_ok),
    .wr_data(push_data),
    .rd_en  (pop_ev),
    .rd_data(rd_data),
    .level  (dlevel)
  );

  logic [SW-1:0] head_raw;
  rxeof_fifo #(.W(SW), .DEPTH(DEPTH)) u_sq (
    .clk, .rst_n,
    .wr_en  (push_ok),
    .wr_data(push_stat),
    .rd_en  (pop_ev),
    .rd_data(head_raw),
    .level  (slevel)
  );
  assign head_stat = stat_t'(head_raw);
  assign head_eof  = head_stat.eof;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q      <= 1'b0;
      ovr_q         <= 1'b0;
      frame_start_q <= 1'b1;
      frame_stat_q  <= '0;
    end else begin
      if (err_reset) begin
        locked_q <= 1'b0;
      end else if (pop_ev && head_eof) begin
        locked_q     <= 1'b1;
        frame_stat_q <= head_stat;
      end
      if (err_reset)      ovr_q <= 1'b0;
      else if (push_drop) ovr_q <= 1'b1;
      if (rx_flag_end)    frame_start_q <= 1'b1;
      else if (push_ev)   frame_start_q <= 1'b0;
    end
  end

  assign rd_valid   = ~q_empty;
  assign rd_resid   = locked_q ? frame_stat_q.resid : head_stat.resid;
  assign rd_crc_err = locked_q ? frame_stat_q.crc : head_stat.crc;
  assign rd_eof     = locked_q | (rd_valid & head_eof);
  assign overrun    = ovr_q;

  rxeof_irq u_irq (
    .mode      (irq_mode_e'(int_mode)),
    .head_valid(rd_valid),
    .head_first(head_stat.first),
    .locked    (locked_q),
    .overrun   (ovr_q),
    .irq       (irq)
  );

endmodule

// File: rtl/rxeof_checker.sv
module rxeof_checker #(
  parameter int DEPTH = 3,
  parameter int QW    = 2,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    int_mode,
  input logic          irq,
  input logic          overrun,
  input logic          locked,
  input logic          err_reset,
  input logic          pop_ev,
  input logic          head_eof,
  input logic          push_ev,
  input logic          q_full,
  input logic          rx_flag_end,
  input logic [CW-1:0] asm_cnt,
  input logic [QW-1:0] dlevel,
  input logic [QW-1:0] slevel,
  input logic          rd_valid,
  input logic          rd_pop,
  input logic [7:0]    rd_data
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dlevel <= QW'(DEPTH)); // R5
  AST_QUEUES_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    dlevel == slevel); // R5
  AST_FLAG_PUSHES_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag_end && asm_cnt != '0) |-> push_ev); // R2
  AST_EOF_POP_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ev && head_eof && !err_reset) |=> locked); // R6
  AST_LOCKED_HOLDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && rd_valid && rd_pop) |=> $stable(rd_data)); // R6
  AST_ERR_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    err_reset |=> (!overrun && !locked)); // R8
  AST_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ev && q_full && !pop_ev && !err_reset) |=> overrun); // R9
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mode == 2'b00) |-> !irq); // R10
  AST_IRQ_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mode != 2'b00 && (locked || overrun)) |-> irq); // R10
endmodule

bind sdlc_rx_eof_status rxeof_checker #(.DEPTH(DEPTH), .QW(QW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .int_mode   (int_mode),
  .irq        (irq),
  .overrun    (overrun),
  .locked     (locked_q),
  .err_reset  (err_reset),
  .pop_ev     (pop_ev),
  .head_eof   (head_eof),
  .push_ev    (push_ev),
  .q_full     (q_full),
  .rx_flag_end(rx_flag_end),
  .asm_cnt    (asm_cnt),
  .dlevel     (dlevel),
  .slevel     (slevel),
  .rd_valid   (rd_valid),
  .rd_pop     (rd_pop),
  .rd_data    (rd_data)
);

// File: tb/tb_sdlc_rx_eof_status.sv
module tb_sdlc_rx_eof_status;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit_vld = 1'b0, rx_bit = 1'b0, rx_flag_end = 1'b0, crc_bad = 1'b0;
  logic [1:0] int_mode = 2'b00;
  logic rd_pop = 1'b0, err_reset = 1'b0;
  logic rd_valid, rd_crc_err, rd_eof, overrun, irq;
  logic [7:0] rd_data;
  logic [2:0] rd_resid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdlc_rx_eof_status dut (
    .clk, .rst_n, .rx_bit_vld, .rx_bit, .rx_flag_end, .crc_bad, .int_mode,
    .rd_pop, .err_reset, .rd_valid, .rd_data, .rd_resid, .rd_crc_err,
    .rd_eof, .overrun, .irq
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected residue code restated as an offset: leftover - 2, modulo 8
  function automatic logic [2:0] exp_resid(input int left);
    return 3'((left + 6) % 8);
  endfunction

  task automatic send_bit(input logic b);
    rx_bit_vld = 1'b1; rx_bit = b;
    @(negedge clk);
    rx_bit_vld = 1'b0; rx_bit = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] v, input int k);
    for (int i = 0; i < k; i++) send_bit(v[i]);
  endtask

  task automatic send_flag(input logic bad);
    rx_flag_end = 1'b1; crc_bad = bad;
    @(negedge clk);
    rx_flag_end = 1'b0; crc_bad = 1'b0;
  endtask

  task automatic pop();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic ereset();
    err_reset = 1'b1;
    @(negedge clk);
    err_reset = 1'b0;
  endtask

  task automatic t_reset();
    chk("R5", "rd_valid after reset", 32'(rd_valid), 0);
    chk("R9", "overrun after reset", 32'(overrun), 0);
    chk("R10", "irq after reset", 32'(irq), 0);
    chk("R6", "rd_eof after reset", 32'(rd_eof), 0);
  endtask

  task automatic t_full_frame();
    int_mode = 2'b11;
    send_bits(8'hA5, 8);
    chk("R1", "complete char held, not yet queued", 32'(rd_valid), 0);
    send_bits(8'h3C, 8);
    send_bits(8'h0F, 8);
    send_flag(1'b0);
    chk("R1", "first char", 32'(rd_data), 32'hA5);
    chk("R3", "non-final eof", 32'(rd_eof), 0);
    chk("R3", "non-final resid", 32'(rd_resid), 32'(exp_resid(0)));
    chk("R10", "special mode, nothing special", 32'(irq), 0);
    pop();
    chk("R1", "second char", 32'(rd_data), 32'h3C);
    pop();
    chk("R2", "final char", 32'(rd_data), 32'h0F);
    chk("R3", "final eof", 32'(rd_eof), 1);
    chk("R3", "final resid 0 leftover", 32'(rd_resid), 32'(exp_resid(0)));
    chk("R4", "crc good", 32'(rd_crc_err), 0);
    chk("R10", "no irq before eof char read", 32'(irq), 0);
    pop();
    chk("R6", "locked eof shown", 32'(rd_eof), 1);
    chk("R10", "irq on lock", 32'(irq), 1);
    chk("R5", "queue empty", 32'(rd_valid), 0);
    ereset();
    chk("R8", "irq cleared by reset command", 32'(irq), 0);
    chk("R8", "eof cleared", 32'(rd_eof), 0);
  endtask

  task automatic t_residue();
    int_mode = 2'b00;
    for (int k = 1; k < 8; k++) begin
      logic [7:0] v;
      logic [7:0] expd;
      logic bad;
      v = 8'h6D ^ 8'(k);
      bad = k[0];
      expd = 8'((int'(v) & ((1 << k) - 1)) << (8 - k));
      send_bits(8'h5A, 8);
      send_bits(v, k);
      send_flag(bad);
      chk("R1", $sformatf("k=%0d lead char", k), 32'(rd_data), 32'h5A);
      pop();
      chk("R2", $sformatf("k=%0d tail data", k), 32'(rd_data), 32'(expd));
      chk("R3", $sformatf("k=%0d resid", k), 32'(rd_resid), 32'(exp_resid(k)));
      chk("R4", $sformatf("k=%0d crc", k), 32'(rd_crc_err), 32'(bad));
      pop();
      chk("R6", $sformatf("k=%0d held resid", k), 32'(rd_resid), 32'(exp_resid(k)));
      chk("R6", $sformatf("k=%0d held crc", k), 32'(rd_crc_err), 32'(bad));
      chk("R10", $sformatf("k=%0d mode off", k), 32'(irq), 0);
      ereset();
    end
    send_flag(1'b0);
    chk("R2", "empty flag queues nothing", 32'(rd_valid), 0);
  endtask

  task automatic t_lock();
    int_mode = 2'b11;
    send_bits(8'h11, 8);
    send_flag(1'b0);
    pop();
    send_bits(8'h22, 8);
    send_bits(8'h33, 8);
    send_flag(1'b0);
    chk("R6", "data queued while locked", 32'(rd_valid), 1);
    pop();
    chk("R6", "pop ignored while locked", 32'(rd_data), 32'h22);
    chk("R6", "still valid", 32'(rd_valid), 1);
    ereset();
    chk("R7", "post-lock char eof forced", 32'(rd_eof), 1);
    chk("R7", "post-lock char resid", 32'(rd_resid), 32'(exp_resid(0)));
    pop();
    chk("R6", "relock on forced eof", 32'(irq), 1);
    ereset();
    chk("R8", "unlocked head", 32'(rd_data), 32'h33);
    pop();
    ereset();
    chk("R5", "drained", 32'(rd_valid), 0);
  endtask

  task automatic t_overrun();
    int_mode = 2'b11;
    send_bits(8'h01, 8);
    send_bits(8'h02, 8);
    send_bits(8'h03, 8);
    send_bits(8'h04, 8);
    send_flag(1'b0);
    chk("R9", "overrun set", 32'(overrun), 1);
    chk("R10", "irq on overrun", 32'(irq), 1);
    ereset();
    chk("R8", "overrun cleared", 32'(overrun), 0);
    chk("R8", "irq cleared", 32'(irq), 0);
    chk("R9", "oldest kept", 32'(rd_data), 32'h01);
    pop();
    chk("R9", "second kept", 32'(rd_data), 32'h02);
    pop();
    chk("R9", "third kept", 32'(rd_data), 32'h03);
    pop();
    chk("R9", "fourth dropped", 32'(rd_valid), 0);
  endtask

  task automatic t_irq_modes();
    send_bits(8'h55, 8);
    send_bits(8'h66, 8);
    send_flag(1'b0);
    int_mode = 2'b01; @(negedge clk);
    chk("R10", "mode 01 first char", 32'(irq), 1);
    int_mode = 2'b11; @(negedge clk);
    chk("R10", "mode 11 plain char", 32'(irq), 0);
    int_mode = 2'b10; @(negedge clk);
    chk("R10", "mode 10 waiting char", 32'(irq), 1);
    pop();
    chk("R10", "mode 10 second char", 32'(irq), 1);
    int_mode = 2'b01; @(negedge clk);
    chk("R10", "mode 01 not first", 32'(irq), 0);
    pop();
    chk("R10", "mode 01 on lock", 32'(irq), 1);
    int_mode = 2'b00; @(negedge clk);
    chk("R10", "mode 00 while locked", 32'(irq), 0);
    ereset();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_frame();
    t_residue();
    t_lock();
    t_overrun();
    t_irq_modes();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule